// File: doc/BRIEF.md
# PCI Interrupt Pin Router

The router takes four level-sensitive PCI interrupt request lines and steers each one onto one of sixteen legacy interrupt-controller inputs. Those sixteen inputs stand for two cascaded eight-input controllers. Software selects each request's destination through a byte-wide routing register. It writes that register through a small configuration write port that has a byte address, an 8-bit data bus and a write strobe. A routing value of 16 or more leaves the request unconnected.

The block keeps its state in a bitmap with one bit for each pair of output line and request. On an ordinary cycle each request refreshes only the bit for the line it is routed to, and only the lines that such a bit belongs to are re-evaluated. When a routing register is written, the bitmap is cleared and refilled from the present request levels under the new routing, and all sixteen outputs are re-driven in the same clock edge. A separate combinational helper turns a device number and its INTx pin into the request number that the slot rotation assigns to it.

Top module: `pirq_router`

## Requirements
- R1: After reset every output is low. Every routing register holds 0x80, which means unrouted, so request activity reaches no output until software writes a routing register.
- R2: The routing register for request n (n = 0..3) is at byte address 0x60+n. A write takes effect at the clock edge that samples the strobe. A write to any other address changes nothing.
- R3: Each output is registered. One cycle after a clock edge, output line L equals the OR of every request that edge sampled high whose routing value equals L.
- R4: A request whose routing value is 16 or greater is ignored. Its level never reaches any output.
- R5: When two or more requests share a line, the line stays high until the last of them goes low.
- R6: A routing write rebuilds the level state at the edge of the write. A request that is already high shows up on its new line in the next cycle. Its old line drops, unless another request still drives that line. No intermediate value appears at the outputs.
- R7: The slot helper is combinational and gives request number (intx + slot - 1) mod 4 for an INTx pin 0..3 and a device number slot.
- R8: No more than four outputs are ever high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address |
| cfgWrData | input | 8 | Configuration write data |
| pirqIn | input | 4 | Level of each PCI interrupt request, bit n is request n |
| irqOut | output | 16 | Registered levels to the interrupt-controller inputs |
| swzSlot | input | 5 | Device number for the slot helper |
| swzIntx | input | 2 | INTx pin (0..3) for the slot helper |
| swzPirq | output | 2 | Request number that the slot helper computes |

## Verification
Some properties hold in every cycle, and the assertions check those: outputs stay clear while reset is held, at most four lines are high at once, all-low requests give all-low outputs one cycle later, and the outputs keep their value when neither the requests nor the routing change. Only the bench scenarios can show the properties that depend on particular routing choices. These are line sharing, disconnection by out-of-range values, ignored writes to neighbouring addresses, rebuild when a held request is moved to a new line, and the slot arithmetic over every device number.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int NUM_PIRQ    = 4;
  localparam int NUM_LINES   = 16;
  localparam int ROUTE_W     = 8;
  localparam int ADDR_W      = 8;
  localparam int SLOT_W      = 5;
  localparam logic [ADDR_W-1:0]  ROUTE_BASE  = 8'h60;
  localparam logic [ROUTE_W-1:0] ROUTE_RESET = 8'h80;

  // strobes from control to datapath
  typedef struct packed {
    logic rebuild;   // routing changed: clear map, reinsert, re-drive all lines
  } rtrStrobe_t;
endpackage

// File: rtl/pirq_route_ctrl.sv
module pirq_route_ctrl
  import pirq_router_pkg::*;
#(
  parameter int NP  = NUM_PIRQ,
  parameter int RW  = ROUTE_W,
  parameter int AW  = ADDR_W,
  parameter logic [AW-1:0] BASE  = ROUTE_BASE,
  parameter logic [RW-1:0] RSTV  = ROUTE_RESET
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [AW-1:0]        cfgAddr,
  input  logic [RW-1:0]        cfgWrData,
  output logic [NP-1:0][RW-1:0] routeNext,
  output rtrStrobe_t           strb
);
  logic [NP-1:0][RW-1:0] routeReg;
  logic [AW-1:0]         offset;
  logic                  hit;

  assign offset = cfgAddr - BASE;
  assign hit    = cfgWrEn && (offset < AW'(NP));

  always_comb begin
    routeNext = routeReg;
    if (hit) routeNext[offset[$clog2(NP)-1:0]] = cfgWrData;
    strb.rebuild = hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) routeReg <= {NP{RSTV}};
    else       routeReg <= routeNext;
  end
endmodule

// File: rtl/pirq_level_dp.sv
module pirq_level_dp
  import pirq_router_pkg::*;
#(
  parameter int NP = NUM_PIRQ,
  parameter int NL = NUM_LINES,
  parameter int RW = ROUTE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NP-1:0]         pirqIn,
  input  logic [NP-1:0][RW-1:0] routeNext,
  input  rtrStrobe_t            strb,
  output logic [NL-1:0]         irqOut
);
  localparam int LW = $clog2(NL);
  localparam int MW = NL * NP;

  logic [MW-1:0] levelMap, mapNext;
  logic [NL-1:0] lineTouch, outNext;

  always_comb begin
    mapNext   = strb.rebuild ? '0 : levelMap;
    lineTouch = {NL{strb.rebuild}};
    for (int p = 0; p < NP; p++) begin
      if (routeNext[p] < RW'(NL)) begin
        mapNext[int'(routeNext[p][LW-1:0]) * NP + p] = pirqIn[p];
        lineTouch[routeNext[p][LW-1:0]] = 1'b1;
      end
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_line
    assign outNext[l] = |mapNext[l*NP +: NP];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelMap <= '0;
      irqOut   <= '0;
    end else begin
      levelMap <= mapNext;
      for (int l = 0; l < NL; l++)
        if (lineTouch[l]) irqOut[l] <= outNext[l];
    end
  end
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_router_pkg::*;
#(
  parameter int NP = NUM_PIRQ,
  parameter int SW = SLOT_W
) (
  input  logic [SW-1:0]          swzSlot,
  input  logic [$clog2(NP)-1:0]  swzIntx,
  output logic [$clog2(NP)-1:0]  swzPirq
);
  localparam int PW = $clog2(NP);
  logic [SW:0] sum;
  // adding NP-1 equals subtracting one modulo NP
  assign sum     = {1'b0, swzSlot} + (SW+1)'(swzIntx) + (SW+1)'(NP - 1);
  assign swzPirq = sum[PW-1:0];
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [ROUTE_W-1:0]    cfgWrData,
  input  logic [NUM_PIRQ-1:0]   pirqIn,
  output logic [NUM_LINES-1:0]  irqOut,
  input  logic [SLOT_W-1:0]     swzSlot,
  input  logic [$clog2(NUM_PIRQ)-1:0] swzIntx,
  output logic [$clog2(NUM_PIRQ)-1:0] swzPirq
);
  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] routeNext;
  rtrStrobe_t strb;

  pirq_route_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .routeNext(routeNext), .strb(strb)
  );

  pirq_level_dp u_dp (
    .clk(clk), .rstN(rstN), .pirqIn(pirqIn), .routeNext(routeNext),
    .strb(strb), .irqOut(irqOut)
  );

  pirq_swizzle u_swz (
    .swzSlot(swzSlot), .swzIntx(swzIntx), .swzPirq(swzPirq)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_router_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgWrEn,
  input logic [NUM_PIRQ-1:0]  pirqIn,
  input logic [NUM_LINES-1:0] irqOut
);
  logic [1:0] armCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armCnt <= '0;
    else if (armCnt != 2'd2) armCnt <= armCnt + 2'd1;
  end

  always @(negedge clk)
    if (!rstN) p_reset_clear_r1: assert (irqOut == '0);

  p_max_lines_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(irqOut) <= NUM_PIRQ);

  p_quiet_inputs_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pirqIn == '0) |=> (irqOut == '0));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armCnt == 2'd2 && $stable(pirqIn) && !cfgWrEn) |=> $stable(irqOut));
endmodule

bind pirq_router pirq_router_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .pirqIn(pirqIn), .irqOut(irqOut)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic [3:0]  pirqIn = '0;
  logic [15:0] irqOut;
  logic [4:0]  swzSlot = '0;
  logic [1:0]  swzIntx = '0;
  logic [1:0]  swzPirq;

  int compared = 0;
  int mismatched = 0;
  int route [4];
  logic [15:0] expOut;
  string curReq = "R1";
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  pirq_router u_pirq_router (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .pirqIn(pirqIn), .irqOut(irqOut),
    .swzSlot(swzSlot), .swzIntx(swzIntx), .swzPirq(swzPirq)
  );

  // behavioural reference
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < 4; p++) route[p] = 128;
      expOut = '0;
    end else begin
      if (cfgWrEn && cfgAddr >= 8'h60 && cfgAddr <= 8'h63)
        route[int'(cfgAddr) - 'h60] = int'(cfgWrData);
      for (int l = 0; l < 16; l++) begin
        expOut[l] = 1'b0;
        for (int p = 0; p < 4; p++)
          if (route[p] == l && pirqIn[p]) expOut[l] = 1'b1;
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
    compared++;
    if (irqOut !== expOut) begin
      mismatched++;
      $display("FAIL %s irqOut actual=%h expected=%h", curReq, irqOut, expOut);
    end
    compared++;
    if ($countones(irqOut) > 4) begin // R8
      mismatched++;
      $display("FAIL R8 lines high actual=%0d expected<=4", $countones(irqOut));
    end
    cfgWrEn = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    cyc();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state, requests unrouted
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    cyc();
    pirqIn = 4'hF; cyc(); cyc();
    pirqIn = 4'h5; cyc();
    pirqIn = 4'h0; cyc();

    // R2 / R3: route request 0 to line 5
    curReq = "R2";
    wr(8'h60, 8'd5);
    curReq = "R3";
    pirqIn = 4'b0001; cyc(); cyc();
    pirqIn = 4'b0000; cyc();

    // R5: request 1 shares line 5
    curReq = "R5";
    wr(8'h61, 8'd5);
    pirqIn = 4'b0011; cyc();
    pirqIn = 4'b0010; cyc(); cyc();
    pirqIn = 4'b0000; cyc();

    // R2: neighbour addresses have no effect
    curReq = "R2";
    wr(8'h64, 8'd7);
    wr(8'h5F, 8'd7);
    pirqIn = 4'b1100; cyc(); cyc();
    pirqIn = 4'b0000; cyc();

    // R4: out-of-range values disconnect
    curReq = "R4";
    wr(8'h62, 8'h10);
    pirqIn = 4'b0100; cyc(); cyc();
    wr(8'h62, 8'hFF);
    pirqIn = 4'b0000; cyc();
    pirqIn = 4'b0100; cyc();
    wr(8'h62, 8'd15);           // last valid line
    cyc();
    pirqIn = 4'b0000; cyc();

    // R6: reroute while held high
    curReq = "R6";
    pirqIn = 4'b0011; cyc();
    wr(8'h60, 8'd9);            // line 5 kept by request 1, 9 rises
    cyc();
    wr(8'h61, 8'd0);            // line 5 drops, line 0 rises
    cyc();
    wr(8'h60, 8'h80);           // request 0 unrouted while high
    cyc();
    pirqIn = 4'b0000; cyc();

    // R3: distinct lines, mixed patterns
    curReq = "R3";
    wr(8'h60, 8'd1); wr(8'h61, 8'd8); wr(8'h62, 8'd14); wr(8'h63, 8'd3);
    for (int i = 0; i < 40; i++) begin
      pirqIn = 4'(i * 7 + (i >> 2));
      if (i == 20) begin cfgWrEn = 1'b1; cfgAddr = 8'h63; cfgWrData = 8'd8; end
      cyc();
    end
    pirqIn = 4'h0; cyc();

    // R7: slot helper over every device number and pin
    for (int s = 0; s < 32; s++)
      for (int x = 0; x < 4; x++) begin
        swzSlot = 5'(s); swzIntx = 2'(x);
        #1;
        compared++;
        if (int'(swzPirq) != ((x + s - 1) % 4 + 4) % 4) begin
          mismatched++;
          $display("FAIL R7 slot=%0d intx=%0d actual=%0d expected=%0d",
                   s, x, swzPirq, ((x + s - 1) % 4 + 4) % 4);
        end
      end

    // R1: reset mid-run clears outputs
    curReq = "R1";
    pirqIn = 4'hF; cyc();
    rstN = 1'b0; cyc();
    rstN = 1'b1; cyc(); cyc();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule